// File: doc/BRIEF.md
# Serial Receiver with Per-Character Error Flags

This block takes an asynchronous serial line and turns it into bytes. It oversamples the line by 16, or by 8 when the double-speed control is set, using an external baud tick. Characters go into a two-slot queue. Each slot keeps the frame-error and parity-error status of the character it holds, so the flags seen at the outputs always belong to the character at the head of the queue. An extra completed character can wait in the shift stage after both slots are full. Overrun is declared only when yet another start bit arrives in that state.

A multi-processor filter keeps only address frames. These are frames whose extra marker bit is 1. The block also builds three interrupt requests: receive complete, transmit complete and data-register empty. Each request needs its own enable and a global enable. The transmit-side status arrives on input pins.

Top module: `serial_rx_core`

## Requirements
- R1: A frame is a low start bit, 8 data bits with the least significant bit first, an optional marker bit when `mp_mode` is 1, an optional parity bit when `par_en` is 1, and a stop bit. The byte read from the head of the queue is `rx_data` and equals the transmitted data byte.
- R2: With `dbl_speed` = 0 each bit lasts 16 baud ticks. With `dbl_speed` = 1 each bit lasts 8 baud ticks.
- R3: After a falling edge, a start is accepted only if the line is still low at the middle sample of the start bit. A shorter low pulse produces no character.
- R4: Each data bit is decided by a majority of three samples taken around the bit centre. A single-sample glitch does not change the received value.
- R5: `rx_ferr` is 1 when the stop bit of the head character was sampled as 0, and 0 when it was sampled as 1.
- R6: `rx_perr` is 1 only when `par_en` was 1 while the head character was received and its parity did not match. Parity covers the data bits, the marker bit when present, and the parity bit. With `par_odd` = 0 the count of ones is even; with `par_odd` = 1 it is odd.
- R7: The queue holds two characters plus one completed character in the shift stage. Reading with `rd_strobe` pops the head, and the waiting character then moves into the queue. `rx_ready` is 1 exactly when the queue holds at least one unread character.
- R8: `rx_ovr` goes to 1 when a start bit is accepted while both slots and the shift stage are full. The incoming character is lost, and the three stored characters are kept. `rx_ovr` clears on the next read.
- R9: With `mp_mode` = 1, frames whose marker bit is 0 never enter the queue. Address frames are stored, with `rx_mark` = 1.
- R10: Each interrupt output is registered. It is 1 one cycle after `gie`, its own enable and its flag are all 1. The flags are `rx_ready`, `tx_done` and `tx_empty`.
- R11: While `rx_en` is 0 the queue, the shift stage and all error flags are cleared. `rx_ready`, `rx_ferr`, `rx_perr` and `rx_ovr` read 0.
- R12: After reset `rx_ready`, `rx_ovr`, all flags and all interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Serial input, idle high |
| baud_tick | input | 1 | One pulse per oversampling period |
| rx_en | input | 1 | Receiver enable; 0 flushes |
| dbl_speed | input | 1 | 1 selects 8 ticks per bit |
| mp_mode | input | 1 | Marker bit present; data frames dropped |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 selects odd parity |
| ie_rxc | input | 1 | Receive-complete interrupt enable |
| ie_txc | input | 1 | Transmit-complete interrupt enable |
| ie_dre | input | 1 | Data-register-empty interrupt enable |
| gie | input | 1 | Global interrupt enable |
| tx_done | input | 1 | Transmit-complete flag from transmitter |
| tx_empty | input | 1 | Data-register-empty flag from transmitter |
| rd_strobe | input | 1 | Pops the head character |
| rx_data | output | 8 | Head character data |
| rx_mark | output | 1 | Head character marker bit |
| rx_ferr | output | 1 | Head character frame error |
| rx_perr | output | 1 | Head character parity error |
| rx_ovr | output | 1 | Overrun flag |
| rx_ready | output | 1 | Queue not empty |
| irq_rxc | output | 1 | Receive-complete request |
| irq_txc | output | 1 | Transmit-complete request |
| irq_dre | output | 1 | Data-register-empty request |

## Verification
The bench sweeps every byte value at double speed with parity, and a spread of values at normal speed. A bit-order or divisor error shows up as wrong bytes. It sends a fourth character into a full queue and shift stage. A design that counts only the two slots would flag overrun one character early, and one that overwrites the held character would return the wrong third byte. A short low pulse and a single-sample glitch inside a bit check the start qualification and the vote. A frame with a low stop bit and frames with bad parity check that the flags follow the head character and are removed by a flush. All 64 combinations of interrupt enables and transmit flags are driven with the queue empty and with it holding a character.

// File: rtl/srx_pkg.sv
package srx_pkg;
  parameter int unsigned SRX_DW = 8;

  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS} srx_state_t;

  typedef struct packed {
    logic [SRX_DW-1:0] data;
    logic              mark;
    logic              ferr;
    logic              perr;
  } srx_char_t;
endpackage

// File: rtl/srx_sampler.sv
module srx_sampler
  import srx_pkg::*;
#(
  parameter int OS_SLOW = 16,
  parameter int OS_FAST = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  logic      tick,
  input  logic      line,
  input  logic      dbl,
  input  logic      mp,
  input  logic      par_en,
  input  logic      par_odd,
  output logic      start_ok,
  output logic      frm_valid,
  output srx_char_t frm
);
  localparam int CW = $clog2(OS_SLOW);
  localparam int BW = $clog2(SRX_DW + 4);
  localparam int DIW = $clog2(SRX_DW);

  logic            sync1, sync2, s, prev;
  srx_state_t      state;
  logic [CW-1:0]   cnt;
  logic [BW-1:0]   bidx;
  logic            v0, v1;
  logic [SRX_DW-1:0] dat;
  logic            mark, pbit;
  logic            mp_l, par_l, odd_l, dbl_l;
  logic [CW-1:0]   mid_pos, last_pos;
  logic [BW-1:0]   stop_idx;
  logic            vote;

  assign s = sync2;
  assign mid_pos  = dbl_l ? CW'(OS_FAST / 2) : CW'(OS_SLOW / 2);
  assign last_pos = dbl_l ? CW'(OS_FAST - 1) : CW'(OS_SLOW - 1);
  assign stop_idx = BW'(SRX_DW) + BW'(mp_l) + BW'(par_l);
  assign vote = (v0 & v1) | (v0 & s) | (v1 & s);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
    end else begin
      sync1 <= line;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state <= S_IDLE; prev <= 1'b1; cnt <= '0; bidx <= '0;
      v0 <= 1'b0; v1 <= 1'b0; dat <= '0; mark <= 1'b0; pbit <= 1'b0;
      mp_l <= 1'b0; par_l <= 1'b0; odd_l <= 1'b0; dbl_l <= 1'b0;
      start_ok <= 1'b0; frm_valid <= 1'b0; frm <= '0;
    end else begin
      start_ok  <= 1'b0;
      frm_valid <= 1'b0;
      if (tick) begin
        case (state)
          S_IDLE: begin
            prev <= s;
            if (prev && !s) begin
              state <= S_START;
              cnt   <= CW'(1);
              mp_l  <= mp; par_l <= par_en; odd_l <= par_odd; dbl_l <= dbl;
              mark  <= 1'b0; pbit <= 1'b0;
            end
          end
          S_START: begin
            if (cnt == mid_pos && s) begin
              state <= S_IDLE;
              prev  <= s;
            end else begin
              if (cnt == mid_pos) start_ok <= 1'b1;
              if (cnt == last_pos) begin
                state <= S_BITS; cnt <= '0; bidx <= '0;
              end else begin
                cnt <= cnt + CW'(1);
              end
            end
          end
          S_BITS: begin
            if (cnt == mid_pos - CW'(1)) v0 <= s;
            if (cnt == mid_pos) v1 <= s;
            if (cnt == last_pos) begin
              cnt  <= '0;
              bidx <= bidx + BW'(1);
            end else begin
              cnt <= cnt + CW'(1);
            end
            if (cnt == mid_pos + CW'(1)) begin
              if (bidx == stop_idx) begin
                frm_valid <= 1'b1;
                frm.data  <= dat;
                frm.mark  <= mark;
                frm.ferr  <= !vote;
                frm.perr  <= par_l && ((^{dat, mark, pbit}) != odd_l);
                state     <= S_IDLE;
                prev      <= s;
              end else if (bidx < BW'(SRX_DW)) begin
                dat[bidx[DIW-1:0]] <= vote;
              end else if (mp_l && bidx == BW'(SRX_DW)) begin
                mark <= vote;
              end else begin
                pbit <= vote;
              end
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  AST_EMIT_ENDS_FRAME: assert property (@(posedge clk) disable iff (rst)
    frm_valid |-> state == S_IDLE); // R1
  AST_START_IN_START: assert property (@(posedge clk) disable iff (rst)
    start_ok |-> state == S_START); // R3
endmodule

// File: rtl/srx_rxbuf.sv
module srx_rxbuf
  import srx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  logic      push,
  input  srx_char_t push_ch,
  input  logic      mp,
  input  logic      start_ok,
  input  logic      pop_req,
  output srx_char_t head,
  output logic      ready,
  output logic      ovr
);
  localparam int CNTW = $clog2(DEPTH + 1);

  srx_char_t       slot [DEPTH];
  srx_char_t       n_slot [DEPTH];
  srx_char_t       hold, n_hold;
  logic            hv, n_hv, drop, n_drop, n_ovr;
  logic [CNTW-1:0] cnt, n_cnt;
  logic            pop, keep;

  assign pop  = pop_req && (cnt != '0);
  assign keep = !mp || push_ch.mark;

  always_comb begin
    n_slot = slot; n_cnt = cnt; n_hold = hold; n_hv = hv;
    n_drop = drop; n_ovr = ovr;
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) n_slot[i] = slot[i+1];
      n_slot[DEPTH-1] = '0;
      n_cnt = cnt - CNTW'(1);
      n_ovr = 1'b0;
    end
    if (n_hv && n_cnt < CNTW'(DEPTH)) begin
      for (int i = 0; i < DEPTH; i++)
        if (CNTW'(i) == n_cnt) n_slot[i] = n_hold;
      n_cnt  = n_cnt + CNTW'(1);
      n_hv   = 1'b0;
      n_hold = '0;
    end
    if (push) begin
      if (drop) begin
        n_drop = 1'b0;
      end else if (keep && !n_hv) begin
        if (n_cnt < CNTW'(DEPTH)) begin
          for (int i = 0; i < DEPTH; i++)
            if (CNTW'(i) == n_cnt) n_slot[i] = push_ch;
          n_cnt = n_cnt + CNTW'(1);
        end else begin
          n_hold = push_ch;
          n_hv   = 1'b1;
        end
      end
    end
    if (start_ok && n_hv && n_cnt == CNTW'(DEPTH)) begin
      n_ovr  = 1'b1;
      n_drop = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
      cnt <= '0; hold <= '0; hv <= 1'b0; drop <= 1'b0; ovr <= 1'b0;
    end else begin
      slot <= n_slot; cnt <= n_cnt; hold <= n_hold; hv <= n_hv;
      drop <= n_drop; ovr <= n_ovr;
    end
  end

  assign head  = slot[0];
  assign ready = (cnt != '0);

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNTW'(DEPTH)); // R7
  AST_OVR_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr) |-> (cnt == CNTW'(DEPTH)) && hv); // R8
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt == '0) && !ovr); // R11
  AST_EMPTY_NO_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) |-> !slot[0].ferr && !slot[0].perr); // R11
endmodule

// File: rtl/srx_irq.sv
module srx_irq (
  input  logic clk,
  input  logic rst,
  input  logic gie,
  input  logic ie_rxc,
  input  logic ie_txc,
  input  logic ie_dre,
  input  logic f_rxc,
  input  logic f_txc,
  input  logic f_dre,
  output logic irq_rxc,
  output logic irq_txc,
  output logic irq_dre
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_rxc <= 1'b0; irq_txc <= 1'b0; irq_dre <= 1'b0;
    end else begin
      irq_rxc <= gie && ie_rxc && f_rxc;
      irq_txc <= gie && ie_txc && f_txc;
      irq_dre <= gie && ie_dre && f_dre;
    end
  end

  AST_GIE_MASKS_ALL: assert property (@(posedge clk) disable iff (rst)
    !gie |=> !irq_rxc && !irq_txc && !irq_dre); // R10
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import srx_pkg::*;
#(
  parameter int OS_SLOW = 16,
  parameter int OS_FAST = 8,
  parameter int DEPTH   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_line,
  input  logic              baud_tick,
  input  logic              rx_en,
  input  logic              dbl_speed,
  input  logic              mp_mode,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              ie_rxc,
  input  logic              ie_txc,
  input  logic              ie_dre,
  input  logic              gie,
  input  logic              tx_done,
  input  logic              tx_empty,
  input  logic              rd_strobe,
  output logic [SRX_DW-1:0] rx_data,
  output logic              rx_mark,
  output logic              rx_ferr,
  output logic              rx_perr,
  output logic              rx_ovr,
  output logic              rx_ready,
  output logic              irq_rxc,
  output logic              irq_txc,
  output logic              irq_dre
);
  logic      start_ok, frm_valid;
  srx_char_t frm, head;

  srx_sampler #(.OS_SLOW(OS_SLOW), .OS_FAST(OS_FAST)) u_samp (
    .clk(clk), .rst(rst), .en(rx_en), .tick(baud_tick), .line(rx_line),
    .dbl(dbl_speed), .mp(mp_mode), .par_en(par_en), .par_odd(par_odd),
    .start_ok(start_ok), .frm_valid(frm_valid), .frm(frm)
  );

  srx_rxbuf #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst(rst), .en(rx_en), .push(frm_valid), .push_ch(frm),
    .mp(mp_mode), .start_ok(start_ok), .pop_req(rd_strobe),
    .head(head), .ready(rx_ready), .ovr(rx_ovr)
  );

  srx_irq u_irq (
    .clk(clk), .rst(rst), .gie(gie), .ie_rxc(ie_rxc), .ie_txc(ie_txc),
    .ie_dre(ie_dre), .f_rxc(rx_ready), .f_txc(tx_done), .f_dre(tx_empty),
    .irq_rxc(irq_rxc), .irq_txc(irq_txc), .irq_dre(irq_dre)
  );

  assign rx_data = head.data;
  assign rx_mark = head.mark;
  assign rx_ferr = head.ferr;
  assign rx_perr = head.perr;
endmodule

// File: tb/sim_serial_rx_core.sv
module sim_serial_rx_core;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_line = 1'b1, baud_tick = 1'b1, rx_en = 1'b0, dbl_speed = 1'b0;
  logic mp_mode = 1'b0, par_en = 1'b0, par_odd = 1'b0;
  logic ie_rxc = 1'b0, ie_txc = 1'b0, ie_dre = 1'b0, gie = 1'b0;
  logic tx_done = 1'b0, tx_empty = 1'b0, rd_strobe = 1'b0;
  logic [7:0] rx_data;
  logic rx_mark, rx_ferr, rx_perr, rx_ovr, rx_ready, irq_rxc, irq_txc, irq_dre;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  serial_rx_core u0 (
    .clk(clk), .rst(rst), .rx_line(rx_line), .baud_tick(baud_tick),
    .rx_en(rx_en), .dbl_speed(dbl_speed), .mp_mode(mp_mode), .par_en(par_en),
    .par_odd(par_odd), .ie_rxc(ie_rxc), .ie_txc(ie_txc), .ie_dre(ie_dre),
    .gie(gie), .tx_done(tx_done), .tx_empty(tx_empty), .rd_strobe(rd_strobe),
    .rx_data(rx_data), .rx_mark(rx_mark), .rx_ferr(rx_ferr), .rx_perr(rx_perr),
    .rx_ovr(rx_ovr), .rx_ready(rx_ready), .irq_rxc(irq_rxc),
    .irq_txc(irq_txc), .irq_dre(irq_dre)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic v, input int os, input bit glitch);
    for (int c = 0; c < os; c++) begin
      @(negedge clk);
      rx_line = (glitch && c == os / 2) ? ~v : v;
    end
  endtask

  // Frame: start, 8 data LSB first, [marker], [parity], stop; glitch_at picks a data bit
  task automatic send(input logic [7:0] d, input bit hm, input logic m,
                      input bit hp, input logic p, input logic stop,
                      input int os, input int glitch_at);
    bit_out(1'b0, os, 1'b0);
    for (int i = 0; i < 8; i++) bit_out(d[i], os, glitch_at == i);
    if (hm) bit_out(m, os, 1'b0);
    if (hp) bit_out(p, os, 1'b0);
    bit_out(stop, os, 1'b0);
    bit_out(1'b1, 2 * os, 1'b0);
  endtask

  task automatic read_one();
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
  endtask

  function automatic logic par_of(input logic [7:0] d, input logic m, input logic odd);
    return (^{d, m}) ^ odd;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R12 reset state
    check("R12 ready", rx_ready, 0); check("R12 ovr", rx_ovr, 0);
    check("R12 irq", {irq_rxc, irq_txc, irq_dre}, 0);
    rst = 1'b0; rx_en = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R6 sweep at 8 ticks per bit, even parity
    dbl_speed = 1'b1; par_en = 1'b1; par_odd = 1'b0;
    for (int v = 0; v < 256; v++) begin
      send(8'(v), 0, 0, 1, par_of(8'(v), 1'b0, 1'b0), 1'b1, 8, -1);
      check("R2 ready", rx_ready, 1);
      check("R2 data", rx_data, v);
      check("R6 no perr", rx_perr, 0);
      read_one();
      check("R7 empty after read", rx_ready, 0);
    end

    // R1 sweep at 16 ticks per bit, no parity
    dbl_speed = 1'b0; par_en = 1'b0;
    for (int v = 3; v < 256; v += 7) begin
      send(8'(v), 0, 0, 0, 0, 1'b1, 16, -1);
      check("R1 data", rx_data, v);
      check("R5 ferr clear", rx_ferr, 0);
      read_one();
    end

    // R6 odd parity, correct and wrong
    par_en = 1'b1; par_odd = 1'b1;
    send(8'hA5, 0, 0, 1, par_of(8'hA5, 1'b0, 1'b1), 1'b1, 16, -1);
    check("R6 odd ok", rx_perr, 0); read_one();
    send(8'hA5, 0, 0, 1, ~par_of(8'hA5, 1'b0, 1'b1), 1'b1, 16, -1);
    check("R6 odd bad", rx_perr, 1); check("R6 data", rx_data, 8'hA5); read_one();
    par_odd = 1'b0;
    send(8'h3C, 0, 0, 1, ~par_of(8'h3C, 1'b0, 1'b0), 1'b1, 16, -1);
    check("R6 even bad", rx_perr, 1); read_one();
    par_en = 1'b0;

    // R4 single-sample glitch inside data bits
    send(8'h5A, 0, 0, 0, 0, 1'b1, 16, 2);
    check("R4 glitch bit2", rx_data, 8'h5A); read_one();
    send(8'hF0, 0, 0, 0, 0, 1'b1, 16, 7);
    check("R4 glitch bit7", rx_data, 8'hF0); read_one();

    // R3 short low pulse rejected
    @(negedge clk); rx_line = 1'b0;
    repeat (3) @(negedge clk); rx_line = 1'b1;
    repeat (200) @(negedge clk);
    check("R3 no char", rx_ready, 0);

    // R7 R8 two slots, shift stage, then overrun
    send(8'h11, 0, 0, 0, 0, 1'b1, 16, -1);
    send(8'h22, 0, 0, 0, 0, 1'b1, 16, -1);
    send(8'h33, 0, 0, 0, 0, 1'b1, 16, -1);
    check("R8 no ovr yet", rx_ovr, 0);
    check("R7 head first", rx_data, 8'h11);
    send(8'h44, 0, 0, 0, 0, 1'b1, 16, -1);
    check("R8 ovr set", rx_ovr, 1);
    read_one();
    check("R8 ovr cleared", rx_ovr, 0);
    check("R7 second", rx_data, 8'h22);
    read_one();
    check("R8 held kept", rx_data, 8'h33);
    read_one();
    check("R8 lost char", rx_ready, 0);

    // R9 marker filter
    mp_mode = 1'b1;
    send(8'h77, 1, 1'b0, 0, 0, 1'b1, 16, -1);
    check("R9 data frame dropped", rx_ready, 0);
    send(8'h5E, 1, 1'b1, 0, 0, 1'b1, 16, -1);
    check("R9 addr kept", rx_ready, 1);
    check("R9 addr data", rx_data, 8'h5E);
    check("R9 mark", rx_mark, 1);
    read_one();
    par_en = 1'b1;
    send(8'h81, 1, 1'b1, 1, par_of(8'h81, 1'b1, 1'b0), 1'b1, 16, -1);
    check("R6 marker in parity", rx_perr, 0); read_one();
    mp_mode = 1'b0; par_en = 1'b0;

    // R5 frame error, then R11 flush
    send(8'h66, 0, 0, 0, 0, 1'b0, 16, -1);
    check("R5 ferr set", rx_ferr, 1);
    check("R5 data", rx_data, 8'h66);
    send(8'h67, 0, 0, 0, 0, 1'b1, 16, -1);
    check("R5 head ferr held", rx_ferr, 1);
    read_one();
    check("R5 next ferr clear", rx_ferr, 0);
    send(8'h68, 0, 0, 0, 0, 1'b0, 16, -1);
    @(negedge clk); rx_en = 1'b0;
    @(negedge clk); rx_en = 1'b1;
    @(negedge clk);
    check("R11 ready", rx_ready, 0);
    check("R11 ferr", rx_ferr, 0);
    check("R11 ovr", rx_ovr, 0);

    // R10 interrupt gating, queue empty and holding one character
    for (int q = 0; q < 2; q++) begin
      if (q == 1) send(8'h99, 0, 0, 0, 0, 1'b1, 16, -1);
      for (int k = 0; k < 64; k++) begin
        @(negedge clk);
        {gie, ie_rxc, ie_txc, ie_dre, tx_done, tx_empty} = 6'(k);
        @(negedge clk);
        check("R10 rxc", irq_rxc, int'(gie & ie_rxc & (q == 1)));
        check("R10 txc", irq_txc, int'(gie & ie_txc & tx_done));
        check("R10 dre", irq_dre, int'(gie & ie_dre & tx_empty));
      end
    end

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule